// File: doc/BRIEF.md
# Offset-Compensated Transmit Frame Timing Generator

This block keeps track of where the transmitter stands inside a 270-column by 9-row byte frame. A clock enable marks each byte time; on every enabled cycle the position moves on by one byte and wraps at the end of the frame. An external framing pulse re-phases the counter. Because that pulse can reach the block late by a programmable number of byte times, the counter loads the late position instead of zero on the pulse. The frame therefore starts that many bytes earlier than the pulse. An offset outside the frame counts as no delay. Offset compensation is only active when three enables are all set.

The block decodes the current position for the surrounding transmit path. It gives a start-of-frame strobe, the slot that carries the section trace byte and the value to place there, a flag that forces the byte to all ones during alarm indication, and a classification of spare overhead bytes with an output enable that shows whether such a byte is driven as zero or left undriven.

The position is registered. All decoded flags are combinational from the registered position and the current control inputs.

Top module: `frame_timing_gen`

## Requirements
- R1: While `rst` is high, the outputs settle to `row`=0, `col`=0, `sof`=1 and `locked`=0.
- R2: On a clock edge with `byte_en`=1 and `ext_pulse`=0, the linear position (`row`*270+`col`) advances by one, and it wraps from 2429 (row 8, column 269) to 0. When `byte_en`=0 the position holds.
- R3: `sof` is 1 exactly when `row`=0 and `col`=0.
- R4: On a clock edge with `byte_en`=1 and `ext_pulse`=1, and with compensation active, the position loads N=`ofs_val`, reported as `row`=N/270 and `col`=N%270.
- R5: If `ofs_val` is above 2429, a pulse loads position 0. A value of 2429 loads row 8, column 269.
- R6: Compensation is active only when `ext_mode`, `hw_en` and `dly_ctl` are all 1. In every other case a pulse loads position 0 and `ofs_val` has no effect.
- R7: `locked` is 0 from reset until the first edge with `byte_en`=1 and `ext_pulse`=1. It is 1 from then on until the next reset.
- R8: `c1_byte` equals `cpu_c1_val` when both `cpu_c1_en` and `toh_ins_en` are 1. Otherwise it equals 0x01.
- R9: `ais_force` is 1 when `ais_en`=1 and either `col`>=9 (payload or path overhead) or `toh_ins_en`=1. Otherwise it is 0.
- R10: `unused_slot` is 1 for a transport-overhead byte (`col`<9) in a row other than 0 and 3 whose column is not a multiple of 3. `unused_oe` is 0 only when `unused_slot`=1 and `zero_fill`=0.
- R11: `c1_slot` is 1 exactly at `row`=0, `col`=6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| byte_en | input | 1 | One-cycle strobe per byte time |
| ext_pulse | input | 1 | External framing reference, sampled with byte_en |
| ofs_val | input | 12 | Programmed lateness of the reference in byte times |
| ext_mode | input | 1 | External timing mode select |
| hw_en | input | 1 | Hardware enable for offset compensation |
| dly_ctl | input | 1 | Offset compensation control bit |
| cpu_c1_en | input | 1 | Use processor value in the trace slot |
| toh_ins_en | input | 1 | Transport overhead insertion enabled |
| ais_en | input | 1 | Alarm indication signal generation |
| zero_fill | input | 1 | Drive spare overhead bytes as zero |
| cpu_c1_val | input | 8 | Processor-supplied trace byte |
| row | output | 4 | Current row, 0..8 |
| col | output | 9 | Current column, 0..269 |
| sof | output | 1 | Start-of-frame strobe |
| locked | output | 1 | A reference pulse has been seen since reset |
| c1_slot | output | 1 | Current byte is the trace slot |
| c1_byte | output | 8 | Value for the trace slot |
| unused_slot | output | 1 | Current byte is spare overhead |
| unused_oe | output | 1 | Spare overhead byte is driven (as 0x00) |
| ais_force | output | 1 | Force the current byte to all ones |

## Verification
The position and the `locked` flag change on the first clock edge after the cycle in which the byte enable and the pulse were driven. The decoded flags follow that new position at once and also follow the control inputs driven in the same cycle. The driver applies every input together at the falling edge and queues one expected record for the position after the next rising edge. The monitor takes the record 1 ns after that rising edge. At that point both the registered position and the combinational flags are stable, and no input has changed since the record was made.

// File: rtl/frm_pkg.sv
`timescale 1ns/1ps
package frm_pkg;

    localparam int FRM_COLS    = 270;
    localparam int FRM_ROWS    = 9;
    localparam int FRM_BYTES   = FRM_COLS * FRM_ROWS;
    localparam int TOH_COLS    = 9;
    localparam int TRACE_COL   = 6;
    localparam int PTR_ROW     = 3;
    localparam int SPARE_STEP  = 3;
    localparam int OFS_W       = 12;
    localparam int COL_W       = $clog2(FRM_COLS);
    localparam int ROW_W       = $clog2(FRM_ROWS);
    localparam int DATA_W      = 8;
    localparam logic [DATA_W-1:0] DEFAULT_TRACE = 8'h01;

    typedef struct packed {
        logic [ROW_W-1:0] row;
        logic [COL_W-1:0] col;
    } frm_pos_t;

    typedef struct packed {
        logic ext_mode;
        logic hw_en;
        logic dly_ctl;
    } comp_ctl_t;

    typedef struct packed {
        logic sof;
        logic c1_slot;
        logic unused_slot;
        logic toh_col;
    } slot_info_t;

    function automatic logic comp_active(input comp_ctl_t c);
        return c.ext_mode & c.hw_en & c.dly_ctl;
    endfunction

    // Split a linear byte index into row and column by repeated subtraction.
    function automatic frm_pos_t split_pos(input logic [OFS_W-1:0] lin);
        frm_pos_t p;
        logic [OFS_W-1:0] rem;
        rem   = lin;
        p.row = '0;
        for (int r = 0; r < FRM_ROWS - 1; r++) begin
            if (rem >= OFS_W'(FRM_COLS)) begin
                rem   = rem - OFS_W'(FRM_COLS);
                p.row = p.row + ROW_W'(1);
            end
        end
        p.col = COL_W'(rem);
        return p;
    endfunction

endpackage

// File: rtl/frm_offset_sel.sv
`timescale 1ns/1ps
module frm_offset_sel
    import frm_pkg::*;
#(
    parameter int LAST_POS = FRM_BYTES - 1
) (
    input  logic [OFS_W-1:0] ofs_val,
    input  comp_ctl_t        ctl,
    output frm_pos_t         load_pos
);
    localparam logic [OFS_W-1:0] LAST_LIN = OFS_W'(LAST_POS);

    logic             in_range;
    logic [OFS_W-1:0] eff_ofs;

    always_comb begin
        in_range = (ofs_val <= LAST_LIN);
        eff_ofs  = (comp_active(ctl) && in_range) ? ofs_val : '0;
        load_pos = split_pos(eff_ofs);
    end
endmodule

// File: rtl/frm_pos_counter.sv
`timescale 1ns/1ps
module frm_pos_counter
    import frm_pkg::*;
#(
    parameter int COLS = FRM_COLS,
    parameter int ROWS = FRM_ROWS
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     byte_en,
    input  logic     ext_pulse,
    input  frm_pos_t load_pos,
    output frm_pos_t pos,
    output logic     locked
);
    localparam logic [COL_W-1:0] LAST_COL = COL_W'(COLS - 1);
    localparam logic [ROW_W-1:0] LAST_ROW = ROW_W'(ROWS - 1);

    frm_pos_t pos_nxt;

    always_comb begin
        pos_nxt = pos;
        if (ext_pulse) begin
            pos_nxt = load_pos;
        end else if (pos.col == LAST_COL) begin
            pos_nxt.col = '0;
            pos_nxt.row = (pos.row == LAST_ROW) ? '0 : pos.row + ROW_W'(1);
        end else begin
            pos_nxt.col = pos.col + COL_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pos    <= '0;
            locked <= 1'b0;
        end else if (byte_en) begin
            pos <= pos_nxt;
            if (ext_pulse) begin
                locked <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/frm_slot_decode.sv
`timescale 1ns/1ps
module frm_slot_decode
    import frm_pkg::*;
#(
    parameter int OH_COLS = TOH_COLS,
    parameter int C1_COL  = TRACE_COL,
    parameter int FULL_R  = PTR_ROW,
    parameter int STEP    = SPARE_STEP
) (
    input  frm_pos_t          pos,
    input  logic              cpu_c1_en,
    input  logic              toh_ins_en,
    input  logic              ais_en,
    input  logic              zero_fill,
    input  logic [DATA_W-1:0] cpu_c1_val,
    output slot_info_t        info,
    output logic [DATA_W-1:0] c1_byte,
    output logic              unused_oe,
    output logic              ais_force
);
    localparam logic [COL_W-1:0] OH_LIM  = COL_W'(OH_COLS);
    localparam logic [COL_W-1:0] C1_C    = COL_W'(C1_COL);
    localparam logic [ROW_W-1:0] FULL_RW = ROW_W'(FULL_R);
    localparam logic [COL_W-1:0] STEP_C  = COL_W'(STEP);

    logic row_all_used;
    logic col_defined;

    always_comb begin
        info.toh_col     = (pos.col < OH_LIM);
        info.sof         = (pos.row == '0) && (pos.col == '0);
        info.c1_slot     = (pos.row == '0) && (pos.col == C1_C);
        row_all_used     = (pos.row == '0) || (pos.row == FULL_RW);
        col_defined      = ((pos.col % STEP_C) == '0);
        info.unused_slot = info.toh_col && !row_all_used && !col_defined;
        unused_oe        = !info.unused_slot || zero_fill;
        c1_byte          = (cpu_c1_en && toh_ins_en) ? cpu_c1_val : DEFAULT_TRACE;
        ais_force        = ais_en && (!info.toh_col || toh_ins_en);
    end
endmodule

// File: rtl/frame_timing_gen.sv
`timescale 1ns/1ps
module frame_timing_gen
    import frm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              byte_en,
    input  logic              ext_pulse,
    input  logic [OFS_W-1:0]  ofs_val,
    input  logic              ext_mode,
    input  logic              hw_en,
    input  logic              dly_ctl,
    input  logic              cpu_c1_en,
    input  logic              toh_ins_en,
    input  logic              ais_en,
    input  logic              zero_fill,
    input  logic [DATA_W-1:0] cpu_c1_val,
    output logic [ROW_W-1:0]  row,
    output logic [COL_W-1:0]  col,
    output logic              sof,
    output logic              locked,
    output logic              c1_slot,
    output logic [DATA_W-1:0] c1_byte,
    output logic              unused_slot,
    output logic              unused_oe,
    output logic              ais_force
);
    comp_ctl_t  ctl;
    frm_pos_t   load_pos;
    frm_pos_t   pos;
    slot_info_t info;

    assign ctl = '{ext_mode: ext_mode, hw_en: hw_en, dly_ctl: dly_ctl};

    frm_offset_sel u_ofs (
        .ofs_val  (ofs_val),
        .ctl      (ctl),
        .load_pos (load_pos)
    );

    frm_pos_counter u_cnt (
        .clk       (clk),
        .rst       (rst),
        .byte_en   (byte_en),
        .ext_pulse (ext_pulse),
        .load_pos  (load_pos),
        .pos       (pos),
        .locked    (locked)
    );

    frm_slot_decode u_dec (
        .pos        (pos),
        .cpu_c1_en  (cpu_c1_en),
        .toh_ins_en (toh_ins_en),
        .ais_en     (ais_en),
        .zero_fill  (zero_fill),
        .cpu_c1_val (cpu_c1_val),
        .info       (info),
        .c1_byte    (c1_byte),
        .unused_oe  (unused_oe),
        .ais_force  (ais_force)
    );

    assign row         = pos.row;
    assign col         = pos.col;
    assign sof         = info.sof;
    assign c1_slot     = info.c1_slot;
    assign unused_slot = info.unused_slot;
endmodule

// File: rtl/frm_timing_chk.sv
`timescale 1ns/1ps
module frm_timing_chk (
    input logic       clk,
    input logic       rst,
    input logic       byte_en,
    input logic       ext_pulse,
    input logic [11:0] ofs_val,
    input logic       ext_mode,
    input logic       hw_en,
    input logic       dly_ctl,
    input logic       ais_en,
    input logic [3:0] row,
    input logic [8:0] col,
    input logic       sof,
    input logic       locked,
    input logic       unused_slot,
    input logic       unused_oe,
    input logic       ais_force
);
    // R2: no byte enable, no movement
    a_r2_hold: assert property (@(posedge clk) disable iff (rst)
        !byte_en |=> ($stable(row) && $stable(col)));

    // R2: plain advance inside a row
    a_r2_advance: assert property (@(posedge clk) disable iff (rst)
        (byte_en && !ext_pulse && col < 9'd269) |=> (col == $past(col) + 9'd1 && row == $past(row)));

    // R3: last byte of the frame is followed by frame start
    a_r3_wrap_sof: assert property (@(posedge clk) disable iff (rst)
        (byte_en && !ext_pulse && row == 4'd8 && col == 9'd269) |=> sof);

    // R6: pulse without full compensation enable lands on position 0
    a_r6_no_comp: assert property (@(posedge clk) disable iff (rst)
        (byte_en && ext_pulse && !(ext_mode && hw_en && dly_ctl)) |=> (row == 4'd0 && col == 9'd0));

    // R5: out-of-range offset lands on position 0
    a_r5_range: assert property (@(posedge clk) disable iff (rst)
        (byte_en && ext_pulse && ofs_val > 12'd2429) |=> sof);

    // R7: lock is sticky and set by a pulse
    a_r7_sticky: assert property (@(posedge clk) disable iff (rst)
        locked |=> locked);
    a_r7_set: assert property (@(posedge clk) disable iff (rst)
        (byte_en && ext_pulse) |=> locked);

    // R9: no override without the alarm enable
    a_r9_gate: assert property (@(posedge clk) disable iff (rst)
        ais_force |-> ais_en);

    // R10: used bytes are always driven
    a_r10_oe: assert property (@(posedge clk) disable iff (rst)
        !unused_slot |-> unused_oe);
endmodule

bind frame_timing_gen frm_timing_chk chk_i (
    .clk         (clk),
    .rst         (rst),
    .byte_en     (byte_en),
    .ext_pulse   (ext_pulse),
    .ofs_val     (ofs_val),
    .ext_mode    (ext_mode),
    .hw_en       (hw_en),
    .dly_ctl     (dly_ctl),
    .ais_en      (ais_en),
    .row         (row),
    .col         (col),
    .sof         (sof),
    .locked      (locked),
    .unused_slot (unused_slot),
    .unused_oe   (unused_oe),
    .ais_force   (ais_force)
);

// File: tb/frame_timing_gen_tb_top.sv
`timescale 1ns/1ps
module frame_timing_gen_tb_top;
    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic        rst = 1'b1;
    logic        byte_en = 1'b0, ext_pulse = 1'b0;
    logic [11:0] ofs_val = '0;
    logic        ext_mode = 0, hw_en = 0, dly_ctl = 0;
    logic        cpu_c1_en = 0, toh_ins_en = 0, ais_en = 0, zero_fill = 0;
    logic [7:0]  cpu_c1_val = '0;
    logic [3:0]  row;
    logic [8:0]  col;
    logic        sof, locked, c1_slot, unused_slot, unused_oe, ais_force;
    logic [7:0]  c1_byte;

    frame_timing_gen dut_i (.*);

    typedef struct {
        bit ext_mode, hw_en, dly, pc1, toh, ais, zf;
        logic [7:0]  val;
        logic [11:0] ofs;
    } ctl_t;

    typedef struct {
        int row, col;
        bit sof, locked, c1_slot, unused_slot, unused_oe, ais;
        int c1_byte;
        string tag;
    } exp_t;

    ctl_t c;
    exp_t q[$];
    int n_chk = 0, n_fail = 0;
    int mpos = 0;
    bit mlock = 0;
    bit done = 0;

    task automatic check(bit ok, string req, string what, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Driver: applies inputs at the falling edge and queues the expected state after the next rise.
    task automatic step(bit en, bit pulse, string tag);
        exp_t e;
        int r, k;
        @(negedge clk);
        byte_en = en; ext_pulse = pulse;
        ofs_val = c.ofs; ext_mode = c.ext_mode; hw_en = c.hw_en; dly_ctl = c.dly;
        cpu_c1_en = c.pc1; toh_ins_en = c.toh; ais_en = c.ais; zero_fill = c.zf;
        cpu_c1_val = c.val;
        if (en) begin
            if (pulse) begin
                mpos  = (c.ext_mode && c.hw_en && c.dly && int'(c.ofs) <= 2429) ? int'(c.ofs) : 0;
                mlock = 1;
            end else begin
                mpos = (mpos + 1) % 2430;
            end
        end
        r = mpos / 270; k = mpos % 270;
        e.row = r; e.col = k; e.tag = tag;
        e.sof = (mpos == 0);
        e.locked = mlock;
        e.c1_slot = (r == 0 && k == 6);
        e.c1_byte = (c.pc1 && c.toh) ? int'(c.val) : 1;
        e.ais = c.ais && (k >= 9 || c.toh);
        e.unused_slot = (k < 9) && (r != 0) && (r != 3) && (k % 3 != 0);
        e.unused_oe = !e.unused_slot || c.zf;
        q.push_back(e);
    endtask

    // Monitor
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                check(int'(row) == e.row, e.tag, "row", int'(row), e.row);
                check(int'(col) == e.col, e.tag, "col", int'(col), e.col);
                check(sof == e.sof, "R3", "sof", int'(sof), int'(e.sof));
                check(locked == e.locked, "R7", "locked", int'(locked), int'(e.locked));
                check(c1_slot == e.c1_slot, "R11", "c1_slot", int'(c1_slot), int'(e.c1_slot));
                check(int'(c1_byte) == e.c1_byte, "R8", "c1_byte", int'(c1_byte), e.c1_byte);
                check(ais_force == e.ais, "R9", "ais_force", int'(ais_force), int'(e.ais));
                check(unused_slot == e.unused_slot, "R10", "unused_slot", int'(unused_slot), int'(e.unused_slot));
                check(unused_oe == e.unused_oe, "R10", "unused_oe", int'(unused_oe), int'(e.unused_oe));
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        c = '{ext_mode: 0, hw_en: 0, dly: 0, pc1: 0, toh: 0, ais: 0, zf: 0, val: 8'h00, ofs: 12'd0};
        repeat (3) @(negedge clk);
        // R1: reset state
        check(row == 0 && col == 0, "R1", "position", int'(row) * 270 + int'(col), 0);
        check(sof == 1'b1, "R1", "sof", int'(sof), 1);
        check(locked == 1'b0, "R1", "locked", int'(locked), 0);
        rst = 1'b0;

        // R2: hold without enable, then free run across a row boundary
        repeat (3) step(0, 0, "R2");
        for (int i = 0; i < 300; i++) begin
            step(1, 0, "R2");
            if (i % 50 == 7) step(0, 0, "R2");
        end

        // R4: compensated loads
        c.ext_mode = 1; c.hw_en = 1; c.dly = 1;
        c.ofs = 12'd500;  step(1, 1, "R4");
        repeat (5) step(1, 0, "R4");
        c.ofs = 12'd0;    step(1, 1, "R4");
        c.ofs = 12'd269;  step(1, 1, "R4");
        step(1, 0, "R4");

        // R5: boundary and out-of-range offsets
        c.ofs = 12'd2429; step(1, 1, "R5");
        step(1, 0, "R5");
        c.ofs = 12'd1000; step(1, 0, "R5");
        c.ofs = 12'd2430; step(1, 1, "R5");
        repeat (3) step(1, 0, "R5");
        c.ofs = 12'd4095; step(1, 1, "R5");

        // R6: each missing enable disables compensation
        c.ofs = 12'd100;
        c.ext_mode = 0; step(1, 1, "R6"); step(1, 0, "R6");
        c.ext_mode = 1; c.hw_en = 0; step(1, 1, "R6"); step(1, 0, "R6");
        c.hw_en = 1; c.dly = 0; step(1, 1, "R6"); step(1, 0, "R6");
        c.dly = 1; step(1, 1, "R6");
        c.ext_mode = 0; c.ofs = 12'd0; step(1, 1, "R6");

        // R8..R11: sweep four frames with varied overhead controls
        for (int f = 0; f < 4; f++) begin
            c.pc1 = f[0]; c.toh = f[1]; c.val = 8'hA5 + 8'(f);
            for (int i = 0; i < 2430; i++) begin
                c.ais = i[0]; c.zf = i[1];
                step(1, 0, "R2");
                if (i % 97 == 5) step(0, 0, "R2");
            end
        end

        wait (q.size() == 0);
        @(negedge clk);
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule